// File: doc/BRIEF.md
# Warp Slot Allocator and Dispatcher

This block sits in front of one multiprocessor and admits thread blocks onto its pool of resident warp slots. A launcher presents a thread count. The block turns the count into whole warps of 32 lanes. It checks that the pool has room for every warp of the block and that a block tag is free. It then reserves all of the block's slots in a single cycle. A request of zero threads, or of more than 1024 threads, is refused and allocates nothing.

After admission, the warps of the block come out one per cycle on an assignment port. Each assignment gives the slot number, the scheduler the warp is tied to for its whole life, the first thread index of the warp, and a mask of the lanes that are active. Warps are dealt to the four schedulers from a rotating pointer, so blocks that follow one another stay balanced. When a block finishes, the launcher returns its tag. The block's slots and its tag are free again from the next cycle.

Top module: `warp_slot_dispatch`

## Requirements
- R1: An admitted block of T threads yields ceil(T/32) assignments, one per cycle. The first appears in the cycle after the accepting clock edge. Warp k comes in order k = 0,1,2,... and has base thread index 32*k. asg_last is 1 only on the final warp.
- R2: Bit i of asg_mask is 1 when lane i (thread base+i) is active. Every warp but the last has all 32 bits set. The last warp has its low T-32*(n-1) bits set and the rest clear.
- R3: A request with T = 0 or T > 1024 is refused. req_ready and req_reject are 1, the handshake reserves no slot and no tag, and no assignment follows.
- R4: A valid request is admitted only if the number of free slots (out of 64) is at least its warp count and a tag is free. Otherwise req_ready is 0 and nothing is reserved. A block is never admitted in part.
- R5: An admitted block takes the lowest-numbered free slots. Its warps get those slots in ascending order.
- R6: Warp k of a block goes to scheduler (P + k) mod 4. P is 0 after reset and advances by the warp count of each admitted block.
- R7: done_valid with a live tag frees all slots and the tag of that block, from the next cycle onward. done_valid with a tag that is not live changes nothing.
- R8: req_blk shows the lowest free tag of 16, which is the tag an admitted block receives. With all 16 tags live, a request stalls.
- R9: After reset, no assignment is pending, all 64 slots and all tags are free, and P is 0.
- R10: req_ready is 0 in every cycle in which asg_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request present |
| req_threads | input | 12 | Thread count of the requested block |
| req_ready | output | 1 | Request is taken on this clock edge (admitted or refused) |
| req_reject | output | 1 | Request is refused: thread count out of range |
| req_blk | output | 4 | Tag the block receives if admitted |
| asg_valid | output | 1 | An assignment is presented this cycle |
| asg_blk | output | 4 | Tag of the block that owns the warp |
| asg_slot | output | 6 | Warp slot reserved for the warp |
| asg_sched | output | 2 | Scheduler the warp is tied to |
| asg_base | output | 10 | Index of the warp's first thread within its block |
| asg_mask | output | 32 | Active-lane mask of the warp |
| asg_last | output | 1 | Final warp of the block |
| done_valid | input | 1 | A block has finished |
| done_blk | input | 4 | Tag of the finished block |

## Verification
req_ready, req_reject and req_blk follow the request in the same cycle. The bench drives a request one time unit after a falling edge and reads these outputs before the next rising edge. Warp k of an accepted block is due k+1 falling edges after the request was driven. The bench compares each warp there and expects asg_valid low at the falling edge that follows the last warp. A completion takes effect on the rising edge after it is driven. Its result is observed through the next request's ready, tag and slot choices.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

  // number of warps a block of the given thread count occupies
  function automatic int warps_needed(int threads, int lanes);
    return (threads + lanes - 1) / lanes;
  endfunction

  // active lanes in the final warp of a block (threads > 0)
  function automatic int last_lanes(int threads, int lanes);
    return threads - (warps_needed(threads, lanes) - 1) * lanes;
  endfunction

  // scheduler for warp k when the rotating pointer stands at ptr
  function automatic int sched_pick(int ptr, int k, int nsched);
    return (ptr + k) % nsched;
  endfunction

endpackage

// File: rtl/wsd_admit.sv
module wsd_admit
  import wsd_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int MAX_WARPS = 32,
  parameter int SLOTS     = 64,
  parameter int NTAGS     = 16,
  parameter int THR_W     = 12,
  parameter int CNT_W     = 6,
  parameter int LANE_W    = 6,
  parameter int TAG_W     = 4
) (
  input  logic              req_valid,
  input  logic [THR_W-1:0]  req_threads,
  input  logic              busy,
  input  logic [SLOTS-1:0]  free_mask,
  input  logic [NTAGS-1:0]  tag_free,
  output logic              req_ready,
  output logic              req_reject,
  output logic              admit,
  output logic [SLOTS-1:0]  take_mask,
  output logic [TAG_W-1:0]  take_tag,
  output logic [CNT_W-1:0]  need_warps,
  output logic [LANE_W-1:0] lanes_last
);
  localparam int MAX_THREADS = LANES * MAX_WARPS;

  logic bad;
  logic fits;
  int   need;
  int   cnt;
  logic tag_found;

  always_comb begin
    bad  = (req_threads == '0) || (int'(req_threads) > MAX_THREADS);
    need = bad ? 0 : warps_needed(int'(req_threads), LANES);
    need_warps = CNT_W'(need);
    lanes_last = bad ? '0 : LANE_W'(last_lanes(int'(req_threads), LANES));
  end

  // lowest free slots, as many as the block needs
  always_comb begin
    take_mask = '0;
    cnt = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (free_mask[i] && (cnt < need)) begin
        take_mask[i] = 1'b1;
        cnt = cnt + 1;
      end
    end
  end

  // lowest free tag
  always_comb begin
    take_tag  = '0;
    tag_found = 1'b0;
    for (int t = 0; t < NTAGS; t++) begin
      if (tag_free[t] && !tag_found) begin
        take_tag  = TAG_W'(t);
        tag_found = 1'b1;
      end
    end
  end

  always_comb begin
    fits       = ($countones(free_mask) >= need) && tag_found;
    req_ready  = !busy && (bad || fits);
    req_reject = bad;
    admit      = req_valid && req_ready && !bad;
  end

endmodule

// File: rtl/wsd_slot_table.sv
module wsd_slot_table #(
  parameter int SLOTS = 64,
  parameter int NTAGS = 16,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             admit,
  input  logic [SLOTS-1:0] take_mask,
  input  logic [TAG_W-1:0] take_tag,
  input  logic             done_valid,
  input  logic [TAG_W-1:0] done_blk,
  output logic [SLOTS-1:0] free_mask,
  output logic [NTAGS-1:0] tag_free,
  output logic             release_fire,
  output logic [SLOTS-1:0] rel_mask
);
  logic [SLOTS-1:0] used;
  logic [NTAGS-1:0] live;
  logic [SLOTS-1:0] owned [NTAGS];

  assign release_fire = done_valid && live[done_blk];
  assign rel_mask     = release_fire ? owned[done_blk] : '0;
  assign free_mask    = ~used;
  assign tag_free     = ~live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      live <= '0;
      for (int t = 0; t < NTAGS; t++) owned[t] <= '0;
    end else begin
      used <= (used & ~rel_mask) | (admit ? take_mask : '0);
      if (release_fire) begin
        live[done_blk]  <= 1'b0;
        owned[done_blk] <= '0;
      end
      if (admit) begin
        live[take_tag]  <= 1'b1;
        owned[take_tag] <= take_mask;
      end
    end
  end

endmodule

// File: rtl/wsd_emitter.sv
module wsd_emitter #(
  parameter int LANES   = 32,
  parameter int SLOTS   = 64,
  parameter int NSCHED  = 4,
  parameter int CNT_W   = 6,
  parameter int LANE_W  = 6,
  parameter int TAG_W   = 4,
  parameter int SLOT_W  = 6,
  parameter int SCHED_W = 2,
  parameter int BASE_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               admit,
  input  logic [SLOTS-1:0]   take_mask,
  input  logic [TAG_W-1:0]   take_tag,
  input  logic [CNT_W-1:0]   need_warps,
  input  logic [LANE_W-1:0]  lanes_last,
  output logic               busy,
  output logic               asg_valid,
  output logic [TAG_W-1:0]   asg_blk,
  output logic [SLOT_W-1:0]  asg_slot,
  output logic [SCHED_W-1:0] asg_sched,
  output logic [BASE_W-1:0]  asg_base,
  output logic [LANES-1:0]   asg_mask,
  output logic               asg_last
);
  logic [SLOTS-1:0]   pend;
  logic [CNT_W-1:0]   widx;
  logic [CNT_W-1:0]   nwarps;
  logic [LANE_W-1:0]  ll;
  logic [TAG_W-1:0]   tag_q;
  logic [SCHED_W-1:0] sched_cur;
  logic [SCHED_W-1:0] rr_ptr;
  logic               slot_found;

  assign busy      = |pend;
  assign asg_valid = busy;
  assign asg_blk   = tag_q;
  assign asg_sched = sched_cur;
  assign asg_last  = busy && (widx == nwarps - CNT_W'(1));
  assign asg_base  = BASE_W'(int'(widx) * LANES);

  always_comb begin
    asg_slot   = '0;
    slot_found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (pend[i] && !slot_found) begin
        asg_slot   = SLOT_W'(i);
        slot_found = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++)
      asg_mask[i] = busy && (!asg_last || (i < int'(ll)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      widx      <= '0;
      nwarps    <= '0;
      ll        <= '0;
      tag_q     <= '0;
      sched_cur <= '0;
      rr_ptr    <= '0;
    end else if (admit) begin
      pend      <= take_mask;
      widx      <= '0;
      nwarps    <= need_warps;
      ll        <= lanes_last;
      tag_q     <= take_tag;
      sched_cur <= rr_ptr;
      rr_ptr    <= SCHED_W'((int'(rr_ptr) + int'(need_warps)) % NSCHED);
    end else if (busy) begin
      pend      <= pend & (pend - SLOTS'(1));
      widx      <= widx + CNT_W'(1);
      sched_cur <= (int'(sched_cur) == NSCHED - 1) ? '0 : sched_cur + SCHED_W'(1);
    end
  end

endmodule

// File: rtl/warp_slot_dispatch.sv
module warp_slot_dispatch #(
  parameter int LANES     = 32,
  parameter int MAX_WARPS = 32,
  parameter int SLOTS     = 64,
  parameter int NSCHED    = 4,
  parameter int NTAGS     = 16,
  localparam int THR_W    = $clog2(LANES * MAX_WARPS) + 2,
  localparam int BASE_W   = $clog2(LANES * MAX_WARPS),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int SCHED_W  = $clog2(NSCHED),
  localparam int TAG_W    = $clog2(NTAGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [THR_W-1:0]   req_threads,
  output logic               req_ready,
  output logic               req_reject,
  output logic [TAG_W-1:0]   req_blk,
  output logic               asg_valid,
  output logic [TAG_W-1:0]   asg_blk,
  output logic [SLOT_W-1:0]  asg_slot,
  output logic [SCHED_W-1:0] asg_sched,
  output logic [BASE_W-1:0]  asg_base,
  output logic [LANES-1:0]   asg_mask,
  output logic               asg_last,
  input  logic               done_valid,
  input  logic [TAG_W-1:0]   done_blk
);
  localparam int CNT_W  = $clog2(MAX_WARPS + 1);
  localparam int LANE_W = $clog2(LANES + 1);

  logic               busy;
  logic               admit;
  logic [SLOTS-1:0]   take_mask;
  logic [TAG_W-1:0]   take_tag;
  logic [CNT_W-1:0]   need_warps;
  logic [LANE_W-1:0]  lanes_last;
  logic [SLOTS-1:0]   free_mask;
  logic [NTAGS-1:0]   tag_free;
  logic               release_fire;
  logic [SLOTS-1:0]   rel_mask;

  assign req_blk = take_tag;

  wsd_admit #(
    .LANES(LANES), .MAX_WARPS(MAX_WARPS), .SLOTS(SLOTS), .NTAGS(NTAGS),
    .THR_W(THR_W), .CNT_W(CNT_W), .LANE_W(LANE_W), .TAG_W(TAG_W)
  ) u_admit (
    .req_valid(req_valid), .req_threads(req_threads), .busy(busy),
    .free_mask(free_mask), .tag_free(tag_free),
    .req_ready(req_ready), .req_reject(req_reject), .admit(admit),
    .take_mask(take_mask), .take_tag(take_tag),
    .need_warps(need_warps), .lanes_last(lanes_last)
  );

  wsd_slot_table #(.SLOTS(SLOTS), .NTAGS(NTAGS), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n), .admit(admit), .take_mask(take_mask),
    .take_tag(take_tag), .done_valid(done_valid), .done_blk(done_blk),
    .free_mask(free_mask), .tag_free(tag_free),
    .release_fire(release_fire), .rel_mask(rel_mask)
  );

  wsd_emitter #(
    .LANES(LANES), .SLOTS(SLOTS), .NSCHED(NSCHED), .CNT_W(CNT_W),
    .LANE_W(LANE_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W), .SCHED_W(SCHED_W),
    .BASE_W(BASE_W)
  ) u_emit (
    .clk(clk), .rst_n(rst_n), .admit(admit), .take_mask(take_mask),
    .take_tag(take_tag), .need_warps(need_warps), .lanes_last(lanes_last),
    .busy(busy), .asg_valid(asg_valid), .asg_blk(asg_blk),
    .asg_slot(asg_slot), .asg_sched(asg_sched), .asg_base(asg_base),
    .asg_mask(asg_mask), .asg_last(asg_last)
  );

endmodule

// File: rtl/wsd_checker.sv
module wsd_checker #(
  parameter int LANES   = 32,
  parameter int SLOTS   = 64,
  parameter int NSCHED  = 4,
  parameter int CNT_W   = 6,
  parameter int SCHED_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_reject,
  input logic               admit,
  input logic [SLOTS-1:0]   take_mask,
  input logic [SLOTS-1:0]   used_mask,
  input logic [CNT_W-1:0]   need_warps,
  input logic               asg_valid,
  input logic               asg_last,
  input logic [SCHED_W-1:0] asg_sched,
  input logic [LANES-1:0]   asg_mask,
  input logic               release_fire,
  input logic [SLOTS-1:0]   rel_mask
);

  assert_whole_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    admit |-> ($countones(take_mask) == int'(need_warps)));

  assert_free_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    admit |-> ((take_mask & used_mask) == '0));

  assert_sched_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid && !asg_last) |=>
      (asg_valid && (asg_sched == SCHED_W'((int'($past(asg_sched)) + 1) % NSCHED))));

  assert_reject_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_reject) |=> !asg_valid);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_fire |=> ((used_mask & $past(rel_mask)) == '0));

  assert_full_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid && !asg_last) |-> (&asg_mask));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> !req_ready);

endmodule

bind warp_slot_dispatch wsd_checker #(
  .LANES(LANES), .SLOTS(SLOTS), .NSCHED(NSCHED), .CNT_W(CNT_W), .SCHED_W(SCHED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_reject(req_reject), .admit(admit), .take_mask(take_mask),
  .used_mask(~free_mask), .need_warps(need_warps), .asg_valid(asg_valid),
  .asg_last(asg_last), .asg_sched(asg_sched), .asg_mask(asg_mask),
  .release_fire(release_fire), .rel_mask(rel_mask)
);

// File: tb/warp_slot_dispatch_bench.sv
module warp_slot_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_threads = '0;
  logic        req_ready, req_reject;
  logic [3:0]  req_blk;
  logic        asg_valid;
  logic [3:0]  asg_blk;
  logic [5:0]  asg_slot;
  logic [1:0]  asg_sched;
  logic [9:0]  asg_base;
  logic [31:0] asg_mask;
  logic        asg_last;
  logic        done_valid = 1'b0;
  logic [3:0]  done_blk = '0;

  int n_checks = 0;
  int n_fail = 0;

  // reference model
  bit [63:0] m_used = '0;
  bit        m_live [16];
  bit [63:0] m_own [16];
  int        m_ptr = 0;

  always #2 clk = ~clk;

  warp_slot_dispatch u_warp_slot_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
    .req_ready(req_ready), .req_reject(req_reject), .req_blk(req_blk),
    .asg_valid(asg_valid), .asg_blk(asg_blk), .asg_slot(asg_slot),
    .asg_sched(asg_sched), .asg_base(asg_base), .asg_mask(asg_mask),
    .asg_last(asg_last), .done_valid(done_valid), .done_blk(done_blk)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic launch(input int thr, input string rdy_req, output int tag_out);
    bit bad;
    int n, freecnt, tag, k, lanes, cnt;
    bit tagok, exp_ready;
    int slots [64];
    bit [63:0] tmask;
    longint emask;
    bad = (thr == 0) || (thr > 1024);
    n = bad ? 0 : (thr + 31) / 32;
    freecnt = 0;
    for (int i = 0; i < 64; i++) if (!m_used[i]) freecnt++;
    tag = 0; tagok = 0;
    for (int t = 15; t >= 0; t--) if (!m_live[t]) begin tag = t; tagok = 1; end
    exp_ready = bad || (freecnt >= n && tagok);
    tag_out = -1;
    #1;
    req_valid = 1'b1;
    req_threads = 12'(thr);
    #0.5;
    check(req_ready == exp_ready, rdy_req, longint'(req_ready), longint'(exp_ready));
    if (exp_ready) check(req_reject == bad, "R3", longint'(req_reject), longint'(bad));
    if (exp_ready && !bad) check(req_blk == 4'(tag), "R8", longint'(req_blk), longint'(tag));
    @(negedge clk);
    req_valid = 1'b0;
    if (!exp_ready || bad) begin
      check(asg_valid == 1'b0, bad ? "R3" : "R4", longint'(asg_valid), 0);
      return;
    end
    tmask = '0; cnt = 0;
    for (int i = 0; i < 64; i++)
      if (!m_used[i] && cnt < n) begin slots[cnt] = i; tmask[i] = 1'b1; cnt++; end
    m_used = m_used | tmask;
    m_live[tag] = 1'b1;
    m_own[tag] = tmask;
    tag_out = tag;
    for (k = 0; k < n; k++) begin
      lanes = (k == n - 1) ? thr - 32 * (n - 1) : 32;
      emask = (lanes == 32) ? 64'hFFFF_FFFF : ((64'd1 << lanes) - 1);
      check(asg_valid == 1'b1, "R1", longint'(asg_valid), 1);
      check(asg_blk == 4'(tag), "R8", longint'(asg_blk), longint'(tag));
      check(int'(asg_slot) == slots[k], "R5", longint'(asg_slot), longint'(slots[k]));
      check(int'(asg_sched) == (m_ptr + k) % 4, "R6", longint'(asg_sched), longint'((m_ptr + k) % 4));
      check(int'(asg_base) == 32 * k, "R1", longint'(asg_base), longint'(32 * k));
      check(longint'(asg_mask) == emask, "R2", longint'(asg_mask), emask);
      check(asg_last == (k == n - 1), "R1", longint'(asg_last), longint'(k == n - 1));
      check(req_ready == 1'b0, "R10", longint'(req_ready), 0);
      @(negedge clk);
    end
    check(asg_valid == 1'b0, "R1", longint'(asg_valid), 0);
    m_ptr = (m_ptr + n) % 4;
  endtask

  task automatic finish_blk(input int tag);
    done_valid = 1'b1;
    done_blk = 4'(tag);
    @(negedge clk);
    done_valid = 1'b0;
    if (m_live[tag]) begin
      m_used = m_used & ~m_own[tag];
      m_live[tag] = 1'b0;
      m_own[tag] = '0;
    end
  endtask

  task automatic finish_all();
    for (int t = 0; t < 16; t++) if (m_live[t]) finish_blk(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int tg, a, b, c;
    for (int t = 0; t < 16; t++) begin m_live[t] = 0; m_own[t] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: after reset nothing pending, full pool free
    check(asg_valid == 1'b0, "R9", longint'(asg_valid), 0);
    req_threads = 12'd1024;
    #0.5;
    check(req_ready == 1'b1, "R9", longint'(req_ready), 1);
    check(req_blk == 4'd0, "R9", longint'(req_blk), 0);
    req_threads = '0;
    @(negedge clk);

    // exhaustive thread-count sweep (R1, R2, R6)
    for (int thr = 1; thr <= 1024; thr++) begin
      launch(thr, "R4", tg);
      if (tg >= 0) finish_blk(tg);
    end

    // out-of-range requests (R3)
    launch(0, "R3", tg);
    launch(1025, "R3", tg);
    launch(4095, "R3", tg);

    // fragmentation: lowest free slots are reused (R5, R7)
    launch(256, "R4", a);
    launch(128, "R4", b);
    launch(256, "R4", c);
    finish_blk(b);
    launch(192, "R7", tg);
    finish_all();

    // full pool stalls, release admits (R4, R7)
    launch(1024, "R4", a);
    launch(1024, "R4", b);
    launch(1, "R4", tg);
    check(tg == -1, "R4", longint'(tg), -1);
    finish_blk(a);
    launch(33, "R7", tg);
    finish_all();

    // completion for a tag that is not live has no effect (R7)
    finish_blk(9);
    launch(32, "R7", tg);
    finish_all();

    // tag exhaustion (R8)
    for (int i = 0; i < 16; i++) launch(1, "R8", tg);
    launch(1, "R8", tg);
    check(tg == -1, "R8", longint'(tg), -1);
    finish_blk(5);
    launch(1, "R8", tg);
    check(tg == 5, "R8", longint'(tg), 5);
    finish_all();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule